// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms memory addresses for a 16-bit machine whose memory is split into overlapping 64 KB windows. For each request it adds whichever of a base register (BX or BP), an index register (SI or DI) and a constant the addressing mode names. The constant may be a short signed byte or a full word. It then picks the window (segment) number, either the default implied by the base register or an explicit override. It also forms the 20-bit physical address by shifting the segment left by four bits and adding the offset.

Requests enter on a valid/ready handshake, and results leave on another. A single output register holds one result. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result shows up on the next edge, as `res_valid` for a legal mode or `res_err` for an illegal one. A result stays on the outputs, unchanged, until the consumer raises `res_ready`. While it waits, `req_ready` is low, so back-pressure passes straight to the requester. When the held result is consumed, a new request can be taken in the same cycle.

Top module: `eag_unit`

## Requirements
- R1: On a legal request, `ea_ofs` equals the sum of the selected base value, the selected index value and the displacement term, modulo 2^16. Base codes are 0 none, 1 BX, 2 BP. Index codes are 0 none, 1 SI, 2 DI.
- R2: The displacement term depends on `disp_kind`. Code 0 gives zero. Code 1 sign-extends `disp[7:0]`, and `disp[15:8]` has no effect. Code 2 uses all 16 bits of `disp`.
- R3: With no base and no index register, a word constant (direct mode) gives an offset equal to `disp`, taken as unsigned.
- R4: Without an override, the segment is SS when the base code is BP, and DS in every other case.
- R5: When `ovr_en` is high, `ovr_seg` replaces the default segment. The codes are 0 ES, 1 CS, 2 SS, 3 DS.
- R6: `ea_phys` equals (`ea_seg` × 16 + `ea_ofs`) modulo 2^20.
- R7: A bare BP request (base BP, no index, no displacement) is served as BP plus zero, in segment SS.
- R8: A request is illegal in any of these cases: any selector field holds code 3; no term is present at all; a byte displacement is used alone. An illegal request gives `res_err` instead of `res_valid`, with `ea_ofs`, `ea_seg` and `ea_phys` all zero. `res_valid` and `res_err` are never high together.
- R9: A request taken on a clock edge produces exactly one result, on the following edge. No result appears without an accepted request.
- R10: While a result is held and `res_ready` is low, `req_ready` is low and every result output stays stable.
- R11: After reset, `res_valid`, `res_err` and all address outputs are zero, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| base_sel | input | 2 | Base register: 0 none, 1 BX, 2 BP, 3 reserved |
| idx_sel | input | 2 | Index register: 0 none, 1 SI, 2 DI, 3 reserved |
| disp_kind | input | 2 | Constant: 0 none, 1 byte, 2 word, 3 reserved |
| disp | input | 16 | Constant value |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment: 0 ES, 1 CS, 2 SS, 3 DS |
| bx_val | input | 16 | BX contents |
| bp_val | input | 16 | BP contents |
| si_val | input | 16 | SI contents |
| di_val | input | 16 | DI contents |
| ds_val | input | 16 | DS contents |
| es_val | input | 16 | ES contents |
| ss_val | input | 16 | SS contents |
| cs_val | input | 16 | CS contents |
| res_valid | output | 1 | Legal result held |
| res_err | output | 1 | Illegal request result held |
| res_ready | input | 1 | Consumer takes the held result |
| ea_ofs | output | 16 | Effective offset |
| ea_seg | output | 16 | Chosen segment number |
| ea_phys | output | 20 | Physical address |

## Verification
The hardest case to reach from the ports is a held result that a new request tries to overwrite. To get there, the bench lowers `res_ready` and issues a request. It then presents a second request with different operands while the first result waits, checks that nothing moves, and releases `res_ready`. The result must hand over in that same edge. The address arithmetic is covered by sweeping every selector code against every override choice, using two register sets. One set forces a 16-bit offset wrap, a 20-bit physical wrap and a negative byte constant. The other has a positive byte constant with nonzero upper bits.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {BASE_NONE = 2'd0, BASE_BX = 2'd1, BASE_BP = 2'd2, BASE_RSV = 2'd3} base_e;
  typedef enum logic [1:0] {IDX_NONE = 2'd0, IDX_SI = 2'd1, IDX_DI = 2'd2, IDX_RSV = 2'd3} idx_e;
  typedef enum logic [1:0] {DSP_NONE = 2'd0, DSP_BYTE = 2'd1, DSP_WORD = 2'd2, DSP_RSV = 2'd3} dsp_e;
  typedef enum logic [1:0] {SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3} seg_e;
endpackage

// File: rtl/eag_mode_check.sv
module eag_mode_check
  import eag_pkg::*;
(
  input  base_e base_sel,
  input  idx_e  idx_sel,
  input  dsp_e  disp_kind,
  output logic  legal
);
  logic no_reg;
  always_comb begin
    no_reg = (base_sel == BASE_NONE) && (idx_sel == IDX_NONE);
    legal  = 1'b1;
    if (base_sel == BASE_RSV || idx_sel == IDX_RSV || disp_kind == DSP_RSV) legal = 1'b0;
    // with no register present, only a full word constant forms an address
    if (no_reg && disp_kind != DSP_WORD) legal = 1'b0;
  end
endmodule

// File: rtl/eag_offset_sum.sv
module eag_offset_sum
  import eag_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int SHORT_W = 8
) (
  input  base_e              base_sel,
  input  idx_e               idx_sel,
  input  dsp_e               disp_kind,
  input  logic [OFS_W-1:0]   disp,
  input  logic [OFS_W-1:0]   bx_val,
  input  logic [OFS_W-1:0]   bp_val,
  input  logic [OFS_W-1:0]   si_val,
  input  logic [OFS_W-1:0]   di_val,
  output logic [OFS_W-1:0]   ofs
);
  logic [OFS_W-1:0] short_ext, base_term, idx_term, disp_term;

  generate
    if (SHORT_W < OFS_W) begin : g_ext
      assign short_ext = {{(OFS_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_pass
      assign short_ext = disp;
    end
  endgenerate

  always_comb begin
    case (base_sel)
      BASE_BX: base_term = bx_val;
      BASE_BP: base_term = bp_val;
      default: base_term = '0;
    endcase
    case (idx_sel)
      IDX_SI:  idx_term = si_val;
      IDX_DI:  idx_term = di_val;
      default: idx_term = '0;
    endcase
    case (disp_kind)
      DSP_BYTE: disp_term = short_ext;
      DSP_WORD: disp_term = disp;
      default:  disp_term = '0;
    endcase
    ofs = base_term + idx_term + disp_term;
  end
endmodule

// File: rtl/eag_seg_pick.sv
module eag_seg_pick
  import eag_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  base_e             base_sel,
  input  logic              ovr_en,
  input  seg_e              ovr_seg,
  input  logic [SEG_W-1:0]  ds_val,
  input  logic [SEG_W-1:0]  es_val,
  input  logic [SEG_W-1:0]  ss_val,
  input  logic [SEG_W-1:0]  cs_val,
  output logic [SEG_W-1:0]  seg
);
  seg_e pick;
  always_comb begin
    if (ovr_en)                    pick = ovr_seg;
    else if (base_sel == BASE_BP)  pick = SEG_SS;
    else                           pick = SEG_DS;
    case (pick)
      SEG_ES:  seg = es_val;
      SEG_CS:  seg = cs_val;
      SEG_SS:  seg = ss_val;
      default: seg = ds_val;
    endcase
  end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int SHIFT   = 4,
  parameter int SHORT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         base_sel,
  input  logic [1:0]         idx_sel,
  input  logic [1:0]         disp_kind,
  input  logic [OFS_W-1:0]   disp,
  input  logic               ovr_en,
  input  logic [1:0]         ovr_seg,
  input  logic [OFS_W-1:0]   bx_val,
  input  logic [OFS_W-1:0]   bp_val,
  input  logic [OFS_W-1:0]   si_val,
  input  logic [OFS_W-1:0]   di_val,
  input  logic [OFS_W-1:0]   ds_val,
  input  logic [OFS_W-1:0]   es_val,
  input  logic [OFS_W-1:0]   ss_val,
  input  logic [OFS_W-1:0]   cs_val,
  output logic               res_valid,
  output logic               res_err,
  input  logic               res_ready,
  output logic [OFS_W-1:0]   ea_ofs,
  output logic [OFS_W-1:0]   ea_seg,
  output logic [OFS_W+SHIFT-1:0] ea_phys
);
  localparam int PA_W = OFS_W + SHIFT;

  base_e b_sel;
  idx_e  i_sel;
  dsp_e  d_kind;
  seg_e  o_seg;
  assign b_sel  = base_e'(base_sel);
  assign i_sel  = idx_e'(idx_sel);
  assign d_kind = dsp_e'(disp_kind);
  assign o_seg  = seg_e'(ovr_seg);

  logic              legal, held, accept;
  logic [OFS_W-1:0]  ofs_n, seg_n;
  logic [PA_W-1:0]   phys_n;

  eag_mode_check u_chk_mode (
    .base_sel(b_sel), .idx_sel(i_sel), .disp_kind(d_kind), .legal(legal)
  );

  eag_offset_sum #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ofs (
    .base_sel(b_sel), .idx_sel(i_sel), .disp_kind(d_kind), .disp(disp),
    .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
    .ofs(ofs_n)
  );

  eag_seg_pick #(.SEG_W(OFS_W)) u_seg (
    .base_sel(b_sel), .ovr_en(ovr_en), .ovr_seg(o_seg),
    .ds_val(ds_val), .es_val(es_val), .ss_val(ss_val), .cs_val(cs_val),
    .seg(seg_n)
  );

  // segment scaled by 2^SHIFT plus zero-extended offset, truncated to PA_W
  assign phys_n = {seg_n, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ofs_n};

  assign held      = res_valid | res_err;
  assign req_ready = ~held | res_ready;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      ea_ofs    <= '0;
      ea_seg    <= '0;
      ea_phys   <= '0;
    end else if (accept) begin
      res_valid <= legal;
      res_err   <= ~legal;
      ea_ofs    <= legal ? ofs_n  : '0;
      ea_seg    <= legal ? seg_n  : '0;
      ea_phys   <= legal ? phys_n : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end
  end
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
  parameter int OFS_W = 16,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   res_valid,
  input logic                   res_err,
  input logic                   res_ready,
  input logic [OFS_W-1:0]       ea_ofs,
  input logic [OFS_W-1:0]       ea_seg,
  input logic [OFS_W+SHIFT-1:0] ea_phys
);
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_err)); // R8
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (ea_phys == '0 && ea_ofs == '0 && ea_seg == '0)); // R8
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (res_valid || res_err)); // R9
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && (!(res_valid || res_err) || res_ready))
    |=> (!res_valid && !res_err)); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_valid || res_err) && !res_ready) |-> !req_ready); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_valid || res_err) && !res_ready) |=>
      ($stable(ea_phys) && $stable(ea_ofs) && $stable(ea_seg) &&
       $stable(res_valid) && $stable(res_err))); // R10
endmodule

bind eag_unit eag_unit_chk #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_eag_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_err(res_err), .res_ready(res_ready),
  .ea_ofs(ea_ofs), .ea_seg(ea_seg), .ea_phys(ea_phys)
);

// File: tb/eag_unit_test.sv
`timescale 1ns/1ps
module eag_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, ovr_en, res_valid, res_err, res_ready;
  logic [1:0]  base_sel, idx_sel, disp_kind, ovr_seg;
  logic [15:0] disp, bx_val, bp_val, si_val, di_val, ds_val, es_val, ss_val, cs_val;
  logic [15:0] ea_ofs, ea_seg;
  logic [19:0] ea_phys;

  eag_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .base_sel(base_sel), .idx_sel(idx_sel), .disp_kind(disp_kind), .disp(disp),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
    .ds_val(ds_val), .es_val(es_val), .ss_val(ss_val), .cs_val(cs_val),
    .res_valid(res_valid), .res_err(res_err), .res_ready(res_ready),
    .ea_ofs(ea_ofs), .ea_seg(ea_seg), .ea_phys(ea_phys)
  );

  int total = 0, failed = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_legal(input int b, input int i, input int d);
    if (b == 3 || i == 3 || d == 3) return 0;
    if (b == 0 && i == 0 && d != 2) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] exp_ofs(input int b, input int i, input int d);
    logic [15:0] s;
    s = 16'h0;
    if (b == 1) s = s + bx_val;
    if (b == 2) s = s + bp_val;
    if (i == 1) s = s + si_val;
    if (i == 2) s = s + di_val;
    if (d == 1) s = s + {{8{disp[7]}}, disp[7:0]};
    if (d == 2) s = s + disp;
    return s;
  endfunction

  function automatic logic [15:0] exp_seg(input int b, input int o);
    case (o)
      0: return es_val;
      1: return cs_val;
      2: return ss_val;
      3: return ds_val;
      default: return (b == 2) ? ss_val : ds_val;
    endcase
  endfunction

  // o == 4 means no override
  task automatic drive(input int b, input int i, input int d, input int o);
    base_sel  = 2'(b);
    idx_sel   = 2'(i);
    disp_kind = 2'(d);
    ovr_en    = (o != 4);
    ovr_seg   = 2'(o);
    req_valid = 1'b1;
  endtask

  task automatic expect_result(input int b, input int i, input int d, input int o);
    bit lg;
    logic [15:0] eo, es;
    logic [19:0] ep;
    string tg;
    lg = is_legal(b, i, d);
    check(res_valid == lg && res_err == !lg, "R9 result kind", {res_valid, res_err}, {lg, !lg});
    if (!lg) begin
      check(ea_ofs == 0 && ea_seg == 0 && ea_phys == 0, "R8 illegal zeros", ea_phys, 0);
      return;
    end
    eo = exp_ofs(b, i, d);
    es = exp_seg(b, o);
    ep = ({4'h0, es} << 4) + {4'h0, eo};
    if (b == 0 && i == 0)               tg = "R3 direct offset";
    else if (b == 2 && i == 0 && d == 0) tg = "R7 bare BP offset";
    else if (d == 1)                    tg = "R2 byte constant offset";
    else                                tg = "R1 offset sum";
    check(ea_ofs == eo, tg, ea_ofs, eo);
    if (b == 2 && i == 0 && d == 0 && o == 4) tg = "R7 bare BP segment";
    else if (o != 4)                         tg = "R5 override segment";
    else                                     tg = "R4 default segment";
    check(ea_seg == es, tg, ea_seg, es);
    check(ea_phys == ep, "R6 physical address", ea_phys, ep);
  endtask

  task automatic one_req(input int b, input int i, input int d, input int o);
    @(negedge clk);
    drive(b, i, d, o);
    @(posedge clk);
    #1;
    expect_result(b, i, d, o);
  endtask

  task automatic load_set(input int s);
    if (s == 0) begin
      bx_val = 16'hFFF0; bp_val = 16'h8001; si_val = 16'h0123; di_val = 16'hF00F;
      disp   = 16'h9A85;
      ds_val = 16'hFFFF; es_val = 16'h1234; ss_val = 16'hF800; cs_val = 16'h0A0B;
    end else begin
      bx_val = 16'h0010; bp_val = 16'h7FFE; si_val = 16'h0004; di_val = 16'h0002;
      disp   = 16'h017F;
      ds_val = 16'h0000; es_val = 16'hE000; ss_val = 16'h4321; cs_val = 16'h0FFF;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; res_ready = 1'b1;
    drive(0, 0, 0, 4); req_valid = 1'b0;
    load_set(0);
    repeat (3) @(posedge clk);
    #1;
    check(!res_valid && !res_err && ea_ofs == 0 && ea_seg == 0 && ea_phys == 0,
          "R11 reset outputs", ea_phys, 0);
    check(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
    @(negedge clk) rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      load_set(s);
      for (int b = 0; b < 4; b++)
        for (int i = 0; i < 4; i++)
          for (int d = 0; d < 4; d++)
            for (int o = 0; o < 5; o++)
              one_req(b, i, d, o);
    end

    // R9: dropping the request ends the result stream
    @(negedge clk) req_valid = 1'b0;
    @(posedge clk); #1;
    check(!res_valid && !res_err, "R9 no result without request", {res_valid, res_err}, 0);

    // R10: back-pressure holds result A while request B waits
    load_set(0);
    @(negedge clk);
    res_ready = 1'b0;
    drive(1, 1, 2, 4);
    @(posedge clk); #1;
    expect_result(1, 1, 2, 4);
    @(negedge clk);
    check(req_ready == 1'b0, "R10 ready low while held", req_ready, 0);
    drive(2, 2, 1, 0);
    repeat (3) begin
      @(posedge clk); #1;
      check(ea_ofs == exp_ofs(1, 1, 2) && res_valid, "R10 held offset", ea_ofs, exp_ofs(1, 1, 2));
      check(ea_seg == ds_val, "R10 held segment", ea_seg, ds_val);
    end
    @(negedge clk) res_ready = 1'b1;
    @(posedge clk); #1;
    expect_result(2, 2, 1, 0);
    @(negedge clk) req_valid = 1'b0;
    @(posedge clk); #1;
    check(!res_valid && !res_err, "R10 drained", {res_valid, res_err}, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule